// File: doc/BRIEF.md
# ISA Interrupt Mask and Vector Unit

This block gathers sixteen interrupt request lines into one summary interrupt for a processor. The lines form a low group (requests 0 to 7) and a high group (requests 8 to 15). Each group has two registers. A command register clears that group's pending requests when it is written. A mask register is written with inverted sense: a 1 bit disables the matching request. The two mask bytes together make one 16-bit enable word.

Two read-only vector registers tell the handler which source to serve. The ISA vector gives the lowest-numbered request that is both pending and enabled. The on-board vector scans a separate 15-bit status word and returns the position of its lowest set bit plus one, shifted left by two, so software can use it directly as a word-table offset.

A request becomes pending on a rising edge of its input and stays pending until its group's command register is written. The summary output is raised whenever any pending request is enabled. Accesses use a simple strobe bus. Read data is registered and is valid on the cycle after the read strobe.

Top module: `isa_irq_unit`

## Requirements
- R1: After reset the enable word is 0xFFFF, no request is pending, `irq_out` is 0 and `bus_rdata` is 0.
- R2: A write to address 1 loads the bitwise inverse of `bus_wdata` into enable bits 7:0. Enable bits 15:8 keep their value.
- R3: A write to address 3 loads the bitwise inverse of `bus_wdata` into enable bits 15:8. Enable bits 7:0 keep their value.
- R4: A read of address 1 or address 3 returns the full 16-bit enable word on `bus_rdata` in the cycle after the read strobe.
- R5: A request bit becomes pending one clock after `isa_req` is seen high at a clock edge where it was low at the previous edge. A request held high does not become pending again once it has been cleared. A request held high through reset becomes pending on the first edge after reset.
- R6: A write to address 0 clears pending bits 7:0, and a write to address 2 clears pending bits 15:8. If a new rising edge arrives in the same cycle as the clear, that request stays pending.
- R7: A read of address 4 returns the index (0 to 15) of the lowest set bit of (pending AND enable). It returns 0 when no such bit is set.
- R8: A read of address 5 returns (i+1)<<2, where i is the lowest set bit of `board_stat[14:0]` as sampled at the read edge. It returns 0 when `board_stat` is zero.
- R9: `irq_out` is a register. It equals the OR of (pending AND enable) as it stood one clock earlier.
- R10: Writes to addresses 4 to 7 change neither the enable word nor the pending state. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Registered read data |
| isa_req | input | 16 | Request lines; a rising edge makes the request pending |
| board_stat | input | 15 | On-board interrupt status word |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The assertions check four things on every cycle. A pending bit only rises after an observed rising edge of its request. A clear leaves only same-cycle new edges pending. A mask write installs the inverse of its data while the other group's mask holds. The summary output follows the enabled pending state by exactly one clock. The priority encoders are checked on every evaluation, so any reported index must be a set bit with no lower set bit. Some behaviour only the bench's scenarios can show:
- that the inverted mask bytes appear together as one word on reads through either group;
- that a held-high request stays quiet after it is cleared;
- that the on-board vector is scaled by four;
- that writes to the vector or unused addresses are ignored.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;

  typedef enum logic [2:0] {
    SEL_CMD,
    SEL_MASK,
    SEL_ISA_VEC,
    SEL_BOARD_VEC,
    SEL_NONE
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e  kind;
    logic [7:0] bank;
  } reg_sel_t;

  // Bank k owns a command word at 2k and a mask word at 2k+1.
  // The two vector words follow the last bank.
  function automatic reg_sel_t decode_addr(input int unsigned a, input int unsigned nbanks);
    reg_sel_t s;
    s.bank = 8'(a >> 1);
    if (a < 2 * nbanks)
      s.kind = a[0] ? SEL_MASK : SEL_CMD;
    else if (a == 2 * nbanks)
      s.kind = SEL_ISA_VEC;
    else if (a == 2 * nbanks + 1)
      s.kind = SEL_BOARD_VEC;
    else
      s.kind = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/isa_irq_lowest.sv
// Finds the lowest set bit of a vector.
module isa_irq_lowest #(
  parameter int W     = 16,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  // R7 / R8: the reported index is set and no lower bit is set.
  always_comb begin
    if (found) begin
      a_r7_lowest_is_set: assert (vec[idx]);
      a_r7_nothing_below: assert ((vec & ((W'(1) << idx) - W'(1))) == '0);
    end else begin
      a_r7_none_when_empty: assert (vec == '0);
    end
  end

endmodule

// File: rtl/isa_irq_bank.sv
// One group of request lines: edge capture, pending latch, and inverted mask.
module isa_irq_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] req_in,
  input  logic              clr,
  input  logic              mask_we,
  input  logic [BANK_W-1:0] mask_wdata,
  output logic [BANK_W-1:0] pend,
  output logic [BANK_W-1:0] en
);

  logic [BANK_W-1:0] req_q;
  logic [BANK_W-1:0] rise;

  assign rise = req_in & ~req_q;

  // R5 / R6: set on edge, clear on command; a new edge wins over the clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req_in;
      pend  <= (clr ? '0 : pend) | rise;
    end
  end

  // R1 / R2 / R3: enable resets to all ones and stores the inverse of a mask write.
  always_ff @(posedge clk) begin
    if (rst)
      en <= '1;
    else if (mask_we)
      en <= ~mask_wdata;
  end

  for (genvar i = 0; i < BANK_W; i++) begin : g_bit_chk
    a_r5_set_on_edge: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[i]) |-> ($past(req_in[i]) && !$past(req_q[i])));
  end

  a_r6_clear_leaves_new_edges: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr)) |-> ((pend & ~$past(req_in & ~req_q)) == '0));

  a_r2_mask_inverted: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_we)) |-> (en == ~$past(mask_wdata)));

  // R3: a group's mask only moves on its own write.
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mask_we)) |-> $stable(en));

endmodule

// File: rtl/isa_irq_unit.sv
module isa_irq_unit #(
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int BOARD_W   = 15,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [NUM_BANKS*BANK_W-1:0] bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] isa_req,
  input  logic [BOARD_W-1:0]          board_stat,
  output logic                        irq_out
);
  import isa_irq_pkg::*;

  localparam int DW      = NUM_BANKS * BANK_W;
  localparam int ISA_IW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int BRD_IW  = (BOARD_W > 1) ? $clog2(BOARD_W) : 1;

  reg_sel_t        sel;
  logic [DW-1:0]   pend_all;
  logic [DW-1:0]   en_all;
  logic [DW-1:0]   active;
  logic [ISA_IW-1:0] isa_idx;
  logic            isa_found;
  logic [BRD_IW-1:0] brd_idx;
  logic            brd_found;
  logic [DW-1:0]   isa_vec;
  logic [DW-1:0]   brd_vec;
  logic [DW-1:0]   rd_mux;

  assign sel = decode_addr(32'(bus_addr), NUM_BANKS);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic clr_k;
    logic mask_we_k;
    assign clr_k     = bus_wr && (sel.kind == SEL_CMD)  && (sel.bank == 8'(k));
    assign mask_we_k = bus_wr && (sel.kind == SEL_MASK) && (sel.bank == 8'(k));

    isa_irq_bank #(.BANK_W(BANK_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .req_in    (isa_req[k*BANK_W +: BANK_W]),
      .clr       (clr_k),
      .mask_we   (mask_we_k),
      .mask_wdata(bus_wdata),
      .pend      (pend_all[k*BANK_W +: BANK_W]),
      .en        (en_all[k*BANK_W +: BANK_W])
    );
  end

  assign active = pend_all & en_all;

  // R7: lowest enabled pending request.
  isa_irq_lowest #(.W(DW), .IDX_W(ISA_IW)) u_isa_prio (
    .vec  (active),
    .idx  (isa_idx),
    .found(isa_found)
  );

  // R8: lowest on-board status bit.
  isa_irq_lowest #(.W(BOARD_W), .IDX_W(BRD_IW)) u_board_prio (
    .vec  (board_stat),
    .idx  (brd_idx),
    .found(brd_found)
  );

  assign isa_vec = isa_found ? DW'(isa_idx) : '0;
  assign brd_vec = brd_found ? DW'((32'(brd_idx) + 32'd1) << 2) : '0;

  // R4 / R10: read mux.
  always_comb begin
    unique case (sel.kind)
      SEL_MASK:      rd_mux = en_all;
      SEL_ISA_VEC:   rd_mux = isa_vec;
      SEL_BOARD_VEC: rd_mux = brd_vec;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  // R9: registered summary interrupt.
  always_ff @(posedge clk) begin
    if (rst)
      irq_out <= 1'b0;
    else
      irq_out <= |active;
  end

  a_r1_enable_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_all == '1 && pend_all == '0 && !irq_out));

  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|(pend_all & en_all))));

  a_r10_vector_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr) && $past(sel.kind != SEL_MASK)) |-> $stable(en_all));

endmodule

// File: tb/isa_irq_unit_test.sv
module isa_irq_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic        bus_rd;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] isa_req;
  logic [14:0] board_stat;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference state, built from the requirements.
  logic [15:0] m_req_q, m_pend, m_en;
  logic        m_irq;

  isa_irq_unit uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .isa_req(isa_req), .board_stat(board_stat), .irq_out(irq_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_req_q <= '0; m_pend <= '0; m_en <= 16'hFFFF; m_irq <= 1'b0;
    end else begin
      logic [15:0] clr;
      clr = '0;
      if (bus_wr && bus_addr == 3'd0) clr[7:0]  = 8'hFF;
      if (bus_wr && bus_addr == 3'd2) clr[15:8] = 8'hFF;
      m_req_q <= isa_req;
      m_pend  <= (m_pend & ~clr) | (isa_req & ~m_req_q);
      m_irq   <= |(m_pend & m_en);
      if (bus_wr && bus_addr == 3'd1) m_en[7:0]  <= ~bus_wdata;
      if (bus_wr && bus_addr == 3'd3) m_en[15:8] <= ~bus_wdata;
    end
  end

  function automatic logic [15:0] f_isa_vec(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 16'(i);
    return 16'd0;
  endfunction

  function automatic logic [15:0] f_board_vec(input logic [14:0] v);
    for (int i = 0; i < 15; i++) if (v[i]) return 16'((i + 1) * 4);
    return 16'd0;
  endfunction

  function automatic logic [15:0] f_read(input logic [2:0] a);
    case (a)
      3'd1, 3'd3: return m_en;
      3'd4:       return f_isa_vec(m_pend & m_en);
      3'd5:       return f_board_vec(board_stat);
      default:    return 16'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    do_read(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(SEED));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    isa_req = '0; board_stat = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R4 read of the full enable word from either group
    check(irq_out === 1'b0, "R1 irq", 16'(irq_out), 16'd0);
    check(bus_rdata === 16'd0, "R1 rdata", bus_rdata, 16'd0);
    read_chk(3'd1, 16'hFFFF, "R1/R4 enable via low");
    read_chk(3'd3, 16'hFFFF, "R4 enable via high");
    read_chk(3'd4, 16'd0, "R7 empty vector");
    read_chk(3'd5, 16'd0, "R8 empty status");

    // R5 edge capture, R9 output latency, R7 priority
    isa_req[3] = 1'b1; isa_req[12] = 1'b1;
    step();
    check(irq_out === 1'b0, "R9 not yet", 16'(irq_out), 16'd0);
    step();
    check(irq_out === 1'b1, "R9 raised", 16'(irq_out), 16'd1);
    read_chk(3'd4, 16'd3, "R5/R7 lowest pending");

    // R2 inverted low mask write
    do_write(3'd1, 8'h08);
    read_chk(3'd1, 16'hFFF7, "R2 low mask");
    read_chk(3'd4, 16'd12, "R7 masked skip");

    // R3 inverted high mask write, low byte untouched
    do_write(3'd3, 8'h10);
    read_chk(3'd3, 16'hEFF7, "R3 high mask");
    read_chk(3'd4, 16'd0, "R7 all masked");
    step();
    check(irq_out === 1'b0, "R9 masked low", 16'(irq_out), 16'd0);
    do_write(3'd3, 8'h00);
    read_chk(3'd4, 16'd12, "R3 unmask high");

    // R10 writes to vector and spare addresses ignored
    do_write(3'd4, 8'hFF);
    do_write(3'd6, 8'hFF);
    read_chk(3'd1, 16'hFFF7, "R10 enable kept");
    read_chk(3'd4, 16'd12, "R10 pending kept");
    read_chk(3'd6, 16'd0, "R10 spare read");
    read_chk(3'd7, 16'd0, "R10 spare read 7");

    // R6 group clears; R5 held level does not re-pend
    do_write(3'd2, 8'h20);
    read_chk(3'd4, 16'd0, "R6 high clear");
    do_write(3'd1, 8'h00);
    read_chk(3'd4, 16'd3, "R6 low kept");
    do_write(3'd0, 8'h20);
    read_chk(3'd4, 16'd0, "R6 low clear");
    step();
    read_chk(3'd4, 16'd0, "R5 held level quiet");

    // R6 new edge in the clear cycle wins
    isa_req[3] = 1'b0;
    step();
    isa_req[3] = 1'b1;
    do_write(3'd0, 8'h20);
    read_chk(3'd4, 16'd3, "R6 edge wins");

    // R8 on-board vector
    board_stat = 15'h4000;
    read_chk(3'd5, 16'd60, "R8 top bit");
    board_stat = 15'h0006;
    read_chk(3'd5, 16'd8, "R8 bit1");
    board_stat = 15'h0001;
    read_chk(3'd5, 16'd4, "R8 bit0");

    // Random traffic against the reference state
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [2:0] a;
      logic [15:0] exp;
      isa_req    = isa_req ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      board_stat = 15'($urandom) & 15'($urandom);
      op = int'($urandom % 4);
      a  = 3'($urandom);
      case (op)
        0: do_write(a, 8'($urandom));
        1: begin
          exp = f_read(a);
          do_read(a, d);
          check(d === exp, "R4/R7/R8/R10 random read", d, exp);
        end
        default: step();
      endcase
      check(irq_out === m_irq, "R9 random irq", 16'(irq_out), 16'(m_irq));
    end

    finish_run();
  end

endmodule